// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block turns two 16-bit parallel words into one 32-bit serial ARINC 429 word. A host writes the words through a strobe bus. The select input chooses which half is written: high for the low half, low for the high half. The block then shifts the word out at one bit per transmit clock. A holding buffer accepts the next pair of words while the current word is still on the line, and the block raises a ready flag whenever that buffer is empty. Bit 32 can be replaced by an odd-parity bit. Each word is followed by a fixed run of null bit periods.

The outputs serve three kinds of consumer:
- Serial data, as a plain stream of bits.
- A sync pulse, active low, during the eighth bit of each word.
- Two return-to-zero drive codes for an external differential line driver.

The strobe and select inputs are asynchronous. They are synchronised into the transmit clock domain before use.

Top module: `a429_word_tx`

## Requirements
- R1: A rising edge on `wr_n` writes `din` into the low half when `sel_first` is 1 and into the high half when it is 0. The write takes effect on the third rising clock edge after the strobe rises. A later write to the same half overwrites the earlier one.
- R2: Serial bit 1 is low-half bit 0 and goes out first. Bits 1–16 are low-half bits 0–15, and bits 17–31 are high-half bits 0–14. Each bit lasts one clock period on `ser_out`.
- R3: With `par_en` = 1, bit 32 makes the 32-bit word hold an odd number of ones. With `par_en` = 0, bit 32 is bit 15 of the high half. `par_en` is sampled when the word moves into the shift register.
- R4: Every word is followed by 4 null bit periods in which `ser_out`, `drv_one` and `drv_zero` are 0. When words are queued back to back, each frame spans exactly 36 clocks.
- R5: `rdy` is 1 while the holding buffer is empty. It goes to 0 on the same edge at which a high-half write takes effect.
- R6: The buffer moves into the shift register at the edge that ends the fourth null period. If the line is already idle, it moves at the next edge after the high-half write takes effect. `rdy` returns to 1 on that transfer edge, and bit 1 appears right after it.
- R7: While `rst_n` is 0, all state is cleared. Afterwards `rdy` is 1 and the line stays null until a high-half write arrives.
- R8: `sync_n` is 0 only while the clock is low during bit 8 of a word. At all other times it is 1.
- R9: During a data bit, `drv_one` equals the bit value while the clock is high, and `drv_zero` equals its inverse while the clock is high. Both codes are 0 while the clock is low and throughout idle and null periods.
- R10: While `rdy` is 0, writes to either half are ignored. The word already waiting is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one serial bit per period |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe; data taken on its rising edge |
| sel_first | input | 1 | 1 selects the low half (bits 1–16), 0 selects the high half |
| din | input | 16 | Parallel data word |
| par_en | input | 1 | 1 makes bit 32 an odd-parity bit |
| rdy | output | 1 | Holding buffer empty |
| ser_out | output | 1 | Serial data stream, 0 when idle |
| sync_n | output | 1 | Active-low sync during the low clock phase of bit 8 |
| drv_one | output | 1 | Line driver code for a one, return-to-zero |
| drv_zero | output | 1 | Line driver code for a zero, return-to-zero |

## Verification
The bench drives `wr_n` high at a falling edge. A behavioural model applies that write on the third rising edge after it, which is also when `rdy` falls. The model counts transfers from the same edges: one edge later from idle, or the edge after the fourth null period when words are queued. The serial stream, sync and drive codes are compared twice per cycle: once in the high clock phase and once in the low phase, each one time unit after the edge. This way the return-to-zero codes and the sync pulse are seen in the phase where they are defined. Stimulus covers both parity settings, back-to-back and idle-start transfers, an overwritten low half, writes ignored while the buffer is full, and a reset in the middle of a word.

// File: rtl/a429_word_tx.sv
`timescale 1ns/1ps
module a429_word_tx #(
  parameter int W        = 16,
  parameter int GAP_BITS = 4,
  parameter int SYNC_BIT = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic         sel_first,
  input  logic [W-1:0] din,
  input  logic         par_en,
  output logic         rdy,
  output logic         ser_out,
  output logic         sync_n,
  output logic         drv_one,
  output logic         drv_zero
);
  localparam int FW   = 2 * W;
  localparam int LAST = FW + GAP_BITS - 1;
  localparam int CW   = $clog2(LAST + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_SHIFT = 2'd1, S_GAP = 2'd2;

  logic [2:0]    wr_q;
  logic [1:0]    sel_q;
  logic [W-1:0]  w1, w2;
  logic          full;
  logic [FW-1:0] sh;
  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic          ld, xfer, bit32, act;

  assign ld    = wr_q[1] & ~wr_q[2] & ~full;
  assign xfer  = full & ((st == S_IDLE) | ((st == S_GAP) & (cnt == CW'(LAST))));
  assign bit32 = par_en ? ~^{w2[W-2:0], w1} : w2[W-1];
  assign act   = (st == S_SHIFT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q  <= '1;
      sel_q <= '0;
    end else begin
      wr_q  <= {wr_q[1:0], wr_n};
      sel_q <= {sel_q[0], sel_first};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w1   <= '0;
      w2   <= '0;
      full <= 1'b0;
    end else begin
      if (ld && sel_q[1]) w1 <= din;
      if (ld && !sel_q[1]) begin
        w2   <= din;
        full <= 1'b1;
      end else if (xfer) begin
        full <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      sh  <= '0;
    end else if (xfer) begin
      sh  <= {bit32, w2[W-2:0], w1};
      st  <= S_SHIFT;
      cnt <= '0;
    end else begin
      case (st)
        S_SHIFT: begin
          sh  <= sh >> 1;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(FW - 1)) st <= S_GAP;
        end
        S_GAP: begin
          if (cnt == CW'(LAST)) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end

  assign rdy      = ~full;
  assign ser_out  = act & sh[0];
  assign drv_one  = act & sh[0] & clk;
  assign drv_zero = act & ~sh[0] & clk;
  assign sync_n   = ~(act & (cnt == CW'(SYNC_BIT - 1)) & ~clk);
endmodule

// File: rtl/a429_word_tx_chk.sv
`timescale 1ns/1ps
module a429_word_tx_chk #(
  parameter int W        = 16,
  parameter int GAP_BITS = 4
)(
  input logic       clk,
  input logic       rst_n,
  input logic       rdy,
  input logic       ld,
  input logic       sel_hi,
  input logic [1:0] st,
  input logic [$clog2(2*W+GAP_BITS)-1:0] cnt,
  input logic       drv_one,
  input logic       drv_zero
);
  localparam int CW   = $clog2(2*W + GAP_BITS);
  localparam int LAST = 2*W + GAP_BITS - 1;

  // R9
  always_comb mutex_chk: assert (!(drv_one && drv_zero));

  // R5
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(ld && !sel_hi));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && cnt != CW'(2*W-1)) |=> (st == 2'd1 && cnt == $past(cnt) + 1'b1));

  // R6
  b2b_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && cnt == CW'(LAST) && !rdy) |=> (st == 2'd1 && cnt == '0 && rdy));

  // R4
  gap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && cnt == CW'(LAST) && rdy) |=> (st == 2'd0));
endmodule

bind a429_word_tx a429_word_tx_chk #(.W(W), .GAP_BITS(GAP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .ld(ld), .sel_hi(sel_q[1]),
  .st(st), .cnt(cnt), .drv_one(drv_one), .drv_zero(drv_zero));

// File: tb/test_a429_word_tx.sv
`timescale 1ns/1ps
module test_a429_word_tx;
  logic clk = 1'b0, rst_n = 1'b0, wr_n = 1'b1, sel_first = 1'b0, par_en = 1'b0;
  logic [15:0] din = '0;
  logic rdy, ser_out, sync_n, drv_one, drv_zero;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  a429_word_tx i_a429_word_tx (.clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_first(sel_first),
    .din(din), .par_en(par_en), .rdy(rdy), .ser_out(ser_out), .sync_n(sync_n),
    .drv_one(drv_one), .drv_zero(drv_zero));

  always #2 clk = ~clk;

  // behavioural reference: symbol -1 = null, else bitnum*2 + value
  int cur = -1;
  int symq[$];
  int ld_at[$];
  bit ld_sel[$];
  logic [15:0] ld_dat[$];
  logic [15:0] mw1 = '0, mw2 = '0;
  bit mfull = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      cur = -1; symq.delete(); ld_at.delete(); ld_sel.delete(); ld_dat.delete();
      mw1 = '0; mw2 = '0; mfull = 0;
    end else begin
      bit fo;
      fo = mfull;
      if (symq.size() > 0) cur = symq.pop_front();
      else if (mfull) begin
        bit [31:0] wd;
        wd = {1'b0, mw2[14:0], mw1};
        if (par_en) wd[31] = ($countones(wd[30:0]) % 2 == 0);
        else        wd[31] = mw2[15];
        for (int i = 0; i < 32; i++) symq.push_back((i + 1) * 2 + int'(wd[i]));
        for (int g = 0; g < 4; g++) symq.push_back(-1);
        cur = symq.pop_front();
        mfull = 0;
      end else cur = -1;
      while (ld_at.size() > 0 && ld_at[0] == cyc) begin
        if (!fo) begin
          if (ld_sel[0]) mw1 = ld_dat[0];
          else begin mw2 = ld_dat[0]; mfull = 1; end
        end
        void'(ld_at.pop_front()); void'(ld_sel.pop_front()); void'(ld_dat.pop_front());
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit();
    return (cur >= 0) ? logic'(cur % 2) : 1'b0;
  endfunction

  // high phase: data, ready, drive codes, no sync
  always @(posedge clk) begin
    #1;
    chk("R5 rdy", rdy, !mfull);
    chk("R2 R3 R4 ser_out", ser_out, exp_bit());
    chk("R9 drv_one high phase", drv_one, (cur >= 0) && exp_bit());
    chk("R9 drv_zero high phase", drv_zero, (cur >= 0) && !exp_bit());
    chk("R8 sync_n high phase", sync_n, 1'b1);
  end

  // low phase: return-to-zero and the bit 8 sync pulse
  always @(negedge clk) begin
    #1;
    chk("R9 drv_one low phase", drv_one, 1'b0);
    chk("R9 drv_zero low phase", drv_zero, 1'b0);
    chk("R8 sync_n low phase", sync_n, !((cur >= 0) && (cur / 2 == 8)));
  end

  // R1: strobe rises at a falling edge; the write lands on the third rising edge after it
  task automatic write_word(input bit sel, input logic [15:0] d);
    @(negedge clk);
    sel_first = sel; din = d; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    ld_at.push_back(cyc + 3); ld_sel.push_back(sel); ld_dat.push_back(d);
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    // R7: reset state
    chk("R7 rdy in reset", rdy, 1'b1);
    chk("R7 ser_out in reset", ser_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle(10);
    chk("R7 null after reset", ser_out, 1'b0);

    // R3 odd parity, idle-start transfer (R6)
    par_en = 1'b1;
    write_word(1'b1, 16'h1234);
    write_word(1'b0, 16'h8001);
    // R1: overwrite low half before high half, queued back to back (R6)
    write_word(1'b1, 16'hFFFF);
    write_word(1'b1, 16'hA5C3);
    write_word(1'b0, 16'h7FFE);
    // R10: writes while rdy is low are ignored
    write_word(1'b0, 16'h0000);
    write_word(1'b1, 16'h0F0F);
    wait (rdy === 1'b1);
    // R3 parity off: bit 32 follows high-half bit 15
    @(negedge clk); par_en = 1'b0;
    write_word(1'b1, 16'h0001);
    write_word(1'b0, 16'h8000);
    wait (rdy === 1'b1);
    write_word(1'b1, 16'hFFFE);
    write_word(1'b0, 16'h0000);
    idle(60);
    // R6 late load after gap has finished: idle path
    par_en = 1'b1;
    write_word(1'b1, 16'h0000);
    write_word(1'b0, 16'h0000);
    idle(20);
    // R7: reset in mid-word clears everything
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    chk("R7 rdy mid reset", rdy, 1'b1);
    chk("R7 ser_out mid reset", ser_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle(10);
    write_word(1'b1, 16'hC001);
    write_word(1'b0, 16'h4002);
    idle(50);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule